// File: doc/BRIEF.md
# Instruction-Programmed Static Mesh Router

This block is the switch of one tile in a two-dimensional array of processing tiles. It has five full-duplex 32-bit links: one each toward the north, east, south and west neighbours, and one to the tile's own processor. The connection pattern is not taken from the words in flight. A small schedule memory holds one crossbar setting per step. A program counter walks through that memory, and a jump in the schedule lets a periodic pattern repeat without end. The pattern can change on every cycle. A word reaches the next tile after exactly one registered stage.

Software loads the schedule through a write port while the router is stopped (`run` low). It then raises `run`. An instruction issues only when every input it reads holds a word and every output it writes can take one. Otherwise the whole switch waits, so no word is lost and none is sent twice. A single input may feed several outputs in the same step.

Top module: `static_mesh_switch`

## Requirements
- R1: When an instruction issues, each output it drives shows the selected input's word with `out_valid` high right after that clock edge: one cycle of latency.
- R2: Instruction bits [3k+2:3k] choose the source of output k (0=N, 1=E, 2=S, 3=W, 4=processor). Value 0 leaves the output idle, values 1..5 select input 0..4, and values 6 and 7 also mean idle. An idle output receives no new word.
- R3: An output word whose `out_ready` is low keeps its data and its `out_valid` until it is taken.
- R4: One input may feed several outputs in one instruction. That input's `in_ready` is then high for exactly that one cycle.
- R5: An instruction issues only if every input it selects is valid and every output it drives is empty or being taken in that cycle. Otherwise `in_ready` stays low and the program counter holds.
- R6: After an instruction issues, the program counter advances by one. If bit 15 is set, it loads the target in bits [15+AW:16] instead.
- R7: A write through `cfg_we`/`cfg_addr`/`cfg_data` is stored only while `run` is low. It is ignored while `run` is high.
- R8: Reset and a low `run` force the program counter to 0. After reset all `out_valid` are low. While `run` is low no instruction issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| run | input | 1 | High to execute the schedule, low to stop and allow loading |
| cfg_we | input | 1 | Schedule write enable |
| cfg_addr | input | AW | Schedule write address |
| cfg_data | input | 3*5+1+AW | Schedule word |
| in_data | input | 5 x W | Input words, index 0..4 = N, E, S, W, processor |
| in_valid | input | 5 | Input word present |
| in_ready | output | 5 | Input word consumed this cycle |
| out_data | output | 5 x W | Registered output words |
| out_valid | output | 5 | Output word present |
| out_ready | input | 5 | Downstream takes the output word |

## Verification
The bench goes after partial readiness. An instruction that needs two inputs gets only one of them, and a design that issues anyway would raise `in_ready` and push an unrelated word. A full output whose receiver is not ready must block the next instruction. Holding there checks that a design does not overwrite or drop the waiting word. A multicast from the processor link checks that every copy carries the same word and that the source is consumed once. The bench also checks three further points: that the jump returns to step 0 rather than running on, that a write made while running leaves the schedule unchanged, and that selector codes 6 and 7 produce no output.

// File: rtl/static_mesh_switch.sv
module static_mesh_switch #(
  parameter int W  = 32,
  parameter int AW = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        run,
  input  logic                        cfg_we,
  input  logic [AW-1:0]               cfg_addr,
  input  logic [3*5+AW:0]             cfg_data,
  input  logic [4:0][W-1:0]           in_data,
  input  logic [4:0]                  in_valid,
  output logic [4:0]                  in_ready,
  output logic [4:0][W-1:0]           out_data,
  output logic [4:0]                  out_valid,
  input  logic [4:0]                  out_ready
);
  localparam int NP    = 5;
  localparam int DEPTH = 1 << AW;
  localparam int IW    = 3*NP + 1 + AW;
  localparam int JBIT  = 3*NP;

  logic [IW-1:0] sched [DEPTH];
  logic [AW-1:0] pc;
  logic [IW-1:0] instr;
  logic [NP-1:0] drive, need_in, space;
  logic [NP-1:0][W-1:0] pick;
  logic fire;

  assign instr = sched[pc];

  always_comb begin
    drive   = '0;
    need_in = '0;
    pick    = '0;
    for (int k = 0; k < NP; k++) begin
      logic [2:0] s;
      s = instr[3*k +: 3];
      if (s >= 3'd1 && s <= 3'd5) begin
        drive[k]   = 1'b1;
        need_in[s - 3'd1] = 1'b1;
        pick[k]    = in_data[s - 3'd1];
      end
    end
  end

  assign space    = ~out_valid | out_ready;
  assign fire     = run && ((need_in & ~in_valid) == '0) && ((drive & ~space) == '0);
  assign in_ready = fire ? need_in : '0;

  always_ff @(posedge clk)
    if (cfg_we && !run) sched[cfg_addr] <= cfg_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       pc <= '0;
    else if (!run)    pc <= '0;
    else if (fire)    pc <= instr[JBIT] ? instr[IW-1:JBIT+1] : pc + 1'b1;

  for (genvar k = 0; k < NP; k++) begin : g_out
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        out_valid[k] <= 1'b0;
        out_data[k]  <= '0;
      end else if (fire && drive[k]) begin
        out_valid[k] <= 1'b1;
        out_data[k]  <= pick[k];
      end else if (out_ready[k]) begin
        out_valid[k] <= 1'b0;
      end

    a_r3_hold_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[k] && !out_ready[k] |=> out_valid[k] && $stable(out_data[k]));

    a_r1_one_hop: assert property (@(posedge clk) disable iff (!rst_n)
      fire && drive[k] |=> out_valid[k] && out_data[k] == $past(pick[k]));
  end

  a_r5_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready & ~in_valid) == '0);

  a_r5_pc_holds_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    run && !fire |=> $stable(pc));

  a_r8_stopped_pc_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> pc == '0);

  a_r8_stopped_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> in_ready == '0);
endmodule

// File: tb/test_static_mesh_switch.sv
module test_static_mesh_switch;
  localparam int W = 32, AW = 4, IW = 3*5 + 1 + AW;
  logic clk = 0, rst_n = 0, run = 0, cfg_we = 0;
  logic [AW-1:0] cfg_addr = '0;
  logic [IW-1:0] cfg_data = '0;
  logic [4:0][W-1:0] in_data = '0, out_data;
  logic [4:0] in_valid = '0, in_ready, out_valid, out_ready = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  static_mesh_switch #(.W(W), .AW(AW)) i_static_mesh_switch (.*);

  function automatic logic [IW-1:0] mk(logic [2:0] s0, s1, s2, s3, s4, logic j, logic [AW-1:0] t);
    return {t, j, s4, s3, s2, s1, s0};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [IW-1:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_data = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic drive_in(logic [4:0] iv, logic [4:0] ordy, int tag);
    in_valid = iv; out_ready = ordy;
    for (int i = 0; i < 5; i++) in_data[i] = {8'(i + 1), 16'h0, 8'(tag)};
  endtask

  task automatic chk_data(string req, logic [14:0] src, int stp);
    for (int k = 0; k < 5; k++)
      if (src[3*k +: 3] != 0)
        chk(req, out_data[k], {8'(src[3*k +: 3]), 16'h0, 8'(stp)});
  endtask

  // {in_valid, out_ready, exp in_ready, exp out_valid, exp src {o4..o0}, exp tag}
  localparam logic [42:0] VEC [8] = '{
    {5'b00000, 5'b11111, 5'b00000, 5'b00000, 15'd0, 8'd0},                              // R5 nothing valid
    {5'b00001, 5'b11111, 5'b00000, 5'b00000, 15'd0, 8'd0},                              // R5 one of two
    {5'b01001, 5'b11111, 5'b01001, 5'b00110, {3'd0,3'd0,3'd4,3'd1,3'd0}, 8'd2},         // R1 issue
    {5'b10000, 5'b11101, 5'b00000, 5'b00010, {3'd0,3'd0,3'd0,3'd1,3'd0}, 8'd2},         // R3/R5 blocked
    {5'b10000, 5'b11111, 5'b10000, 5'b01111, {3'd0,3'd5,3'd5,3'd5,3'd5}, 8'd4},         // R4 multicast
    {5'b00110, 5'b11111, 5'b00110, 5'b11000, {3'd2,3'd3,3'd0,3'd0,3'd0}, 8'd5},         // R6 jump step
    {5'b01001, 5'b11111, 5'b01001, 5'b00110, {3'd0,3'd0,3'd4,3'd1,3'd0}, 8'd6},         // R6 back at 0
    {5'b10000, 5'b00000, 5'b00000, 5'b00110, {3'd0,3'd0,3'd4,3'd1,3'd0}, 8'd6}          // R3 held
  };

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 out_valid after reset", out_valid, 5'b0);
    chk("R8 in_ready after reset", in_ready, 5'b0);
    rst_n = 1;
    wr(0, mk(0, 1, 4, 0, 0, 0, 0));
    wr(1, mk(5, 5, 5, 5, 0, 0, 0));
    wr(2, mk(0, 0, 0, 3, 2, 1, 0));
    @(negedge clk); run = 1;

    for (int v = 0; v < 8; v++) begin
      logic [42:0] e;
      e = VEC[v];
      @(negedge clk); drive_in(e[42:38], e[37:33], v);
      #1 chk($sformatf("R5 in_ready vec%0d", v), in_ready, e[32:28]);
      @(posedge clk); #1;
      chk($sformatf("R1 out_valid vec%0d", v), out_valid, e[27:23]);
      chk_data($sformatf("R2 data vec%0d", v), e[22:8], e[7:0]);
    end

    // R7: write while running is ignored; step 1 still multicasts the processor word
    @(negedge clk); drive_in(5'b00000, 5'b00000, 8);
    cfg_we = 1; cfg_addr = 1; cfg_data = mk(0, 0, 0, 0, 1, 0, 0);
    @(negedge clk); cfg_we = 0; drive_in(5'b10000, 5'b11111, 8);
    #1 chk("R7 write while running ignored", in_ready, 5'b10000);
    @(posedge clk); #1;
    chk("R4 multicast valid", out_valid, 5'b01111);
    chk_data("R4 multicast data", {3'd0,3'd5,3'd5,3'd5,3'd5}, 8);

    // R8: stop with all inputs offered, nothing issues, outputs drain
    @(negedge clk); run = 0; drive_in(5'b11111, 5'b11111, 9);
    #1 chk("R8 no issue while stopped", in_ready, 5'b0);
    @(negedge clk); #1 chk("R8 drained while stopped", out_valid, 5'b0);
    // R7 write while stopped takes effect; R2 codes 6/7 are idle; R8 restart from step 0
    wr(0, mk(6, 7, 0, 0, 1, 0, 0));
    @(negedge clk); run = 1; drive_in(5'b00001, 5'b11111, 10);
    #1 chk("R8 restart at step 0 / R7 write kept", in_ready, 5'b00001);
    @(posedge clk); #1;
    chk("R2 codes 6/7 idle", out_valid, 5'b10000);
    chk_data("R2 out4 from north", {3'd1,12'd0}, 10);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule